// File: doc/BRIEF.md
# Multichannel Sample Address Sequencer

This block starts, stops and steps six sample playback channels. The host sets up each channel through byte-wide register writes. It gives a 16-bit start page and a 16-bit stop page, where one page is 256 bytes. A single command register then starts or stops any group of channels at once. Each running channel walks a 24-bit byte address from the first byte of its start page to the last byte of its stop page. One byte is consumed each time the shared memory port accepts that channel's request.

A round-robin arbiter picks which running channel drives the shared memory request. When a channel's last byte is accepted, the channel stops by itself and raises a one-cycle end pulse on its own bit. The block also keeps per-channel output levels and a master volume. These values are only stored and passed out for the downstream stages.

Top module: `smp_seq_top`

## Requirements
- R1: After reset all channels are idle. `memReq`, `endPulse`, `chanActive`, `masterVol` and `chanLevel` are all zero, and every page register is zero.
- R2: A write to address 0x00 with bit 7 = 0 starts each channel whose select bit is set. Bit n (n = 0..5) selects channel n+1, which is `chanActive[n]`. A started channel's byte address becomes its start page × 256. Channels whose select bit is clear are not affected.
- R3: A write to address 0x00 with bit 7 = 1 stops each selected channel without an end pulse. Unselected channels keep running.
- R4: Channel n (n = 0..5) has four page registers:
  - start page low byte at 0x10+n
  - start page high byte at 0x18+n
  - stop page low byte at 0x20+n
  - stop page high byte at 0x28+n
- R5: While `memReq` is high, `memAddr` is the current byte address of channel `memChan`, counted from 0. That address moves up by one only in a cycle where `memAck` is high.
- R6: The grant goes to the first running channel at or after a rotating pointer, wrapping from 5 to 0. After reset the pointer is 0. Each accepted request moves the pointer to the granted channel + 1, modulo 6.
- R7: The channel's last byte is stop page × 256 + 255. When that byte is accepted, the channel stops. Its `endPulse` bit is then high for exactly the one following cycle.
- R8: Starting a channel that is already running reloads its address from its start page.
- R9: A start or stop command for a channel takes priority over a request accepted for that channel in the same cycle. The accepted byte causes no step and no end pulse.
- R10: Address 0x01 stores the master volume: data bits 5..0 appear on `masterVol`. Address 0x08+n stores all 8 bits for channel n on `chanLevel[8n+7:8n]`. Bit 7 is the left enable, bit 6 is the right enable and bits 5..0 are the level.
- R11: Writes to any other address change no stored state and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register address |
| regWrData | input | 8 | Register write data |
| memReq | output | 1 | Read request from the granted channel |
| memChan | output | 3 | Index of the granted channel |
| memAddr | output | 24 | Byte address of the granted channel |
| memAck | input | 1 | Memory port accepts the current request |
| endPulse | output | 6 | One-cycle end event for each channel |
| chanActive | output | 6 | Running state of each channel |
| masterVol | output | 6 | Stored master volume |
| chanLevel | output | 48 | Stored per-channel pan and level bytes |

## Verification
Some rules are checked by assertions on every cycle:
- an end pulse only follows an accepted request and coincides with the channel going idle;
- a stop command never yields an end pulse;
- the grant always points at a running channel;
- a start reloads the address from the start page;
- an accepted step adds exactly one.

Other rules need the bench's scenarios and its cycle-level reference model:
- the exact round-robin order among running channels;
- the point at which the last byte of the stop page is reached;
- the priority of a command over an acknowledge in the same cycle;
- that unmapped writes are ignored.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int NUM_CH = 6;
  localparam int PAGE_W = 16;
  localparam int ADDR_W = PAGE_W + 8;
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int LVL_W  = 8;
  localparam int MVOL_W = 6;

  typedef struct packed {
    logic [NUM_CH-1:0] keyOn;
    logic [NUM_CH-1:0] step;
    logic              pageWr;
    logic              pageIsStop;
    logic              pageIsHigh;
    logic              levelWr;
    logic              masterWr;
    logic [CH_W-1:0]   regCh;
    logic [7:0]        wrData;
  } seq_strobe_t;
endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [7:0]        regAddr,
  input  logic [7:0]        regWrData,
  input  logic              memAck,
  input  logic [NUM_CH-1:0] atLast,
  output logic              memReq,
  output logic [CH_W-1:0]   memChan,
  output logic [NUM_CH-1:0] endPulse,
  output logic [NUM_CH-1:0] chanActive,
  output seq_strobe_t       strb
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  logic              cmdWr;
  logic [NUM_CH-1:0] keyOn, keyOff, stepOh, finish;
  logic [CH_W-1:0]   rrPtr, grant;
  logic              ack;

  assign cmdWr  = regWrEn && (regAddr == 8'h00);
  assign keyOn  = (cmdWr && !regWrData[7]) ? regWrData[NUM_CH-1:0] : '0;
  assign keyOff = (cmdWr &&  regWrData[7]) ? regWrData[NUM_CH-1:0] : '0;

  always_comb begin
    logic found;
    int idx;
    found = 1'b0;
    grant = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      idx = int'(rrPtr) + k;
      if (idx >= NUM_CH) idx = idx - NUM_CH;
      if (!found && chanActive[idx]) begin
        found = 1'b1;
        grant = CH_W'(idx);
      end
    end
  end

  assign memReq  = |chanActive;
  assign memChan = grant;
  assign ack     = memReq && memAck;

  always_comb begin
    stepOh = '0;
    if (ack) stepOh[grant] = 1'b1;
  end

  assign finish = stepOh & atLast & ~keyOn & ~keyOff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanActive <= '0;
      endPulse   <= '0;
      rrPtr      <= '0;
    end else begin
      chanActive <= (chanActive & ~keyOff & ~finish) | keyOn;
      endPulse   <= finish;
      if (ack) rrPtr <= (grant == LAST_CH) ? '0 : grant + 1'b1;
    end
  end

  always_comb begin
    strb            = '0;
    strb.keyOn      = keyOn;
    strb.step       = stepOh & ~keyOn;
    strb.pageWr     = regWrEn && (regAddr[7:6] == 2'b00) &&
                      ((regAddr[5:4] == 2'b01) || (regAddr[5:4] == 2'b10)) &&
                      (int'(regAddr[2:0]) < NUM_CH);
    strb.pageIsStop = regAddr[5];
    strb.pageIsHigh = regAddr[3];
    strb.levelWr    = regWrEn && (regAddr[7:3] == 5'b00001) &&
                      (int'(regAddr[2:0]) < NUM_CH);
    strb.masterWr   = regWrEn && (regAddr == 8'h01);
    strb.regCh      = regAddr[CH_W-1:0];
    strb.wrData     = regWrData;
  end

  // R7: an end pulse always follows an accepted request
  assert_end_after_ack_R7: assert property (@(posedge clk) disable iff (!rstN)
    (|endPulse) |-> $past(memReq && memAck));
  // R7: a channel is idle while its end pulse is shown
  assert_end_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    (|endPulse) |-> ((endPulse & chanActive) == '0));
  // R7: no end pulse lasts two cycles
  assert_end_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    (|endPulse) |=> ((endPulse & $past(endPulse)) == '0));
  // R3: a stop command never produces an end pulse
  assert_stop_no_end_R3: assert property (@(posedge clk) disable iff (!rstN)
    (|keyOff) |=> ((endPulse & $past(keyOff)) == '0));
  // R6: the grant targets a running channel
  assert_grant_active_R6: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> chanActive[memChan]);
endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  seq_strobe_t             strb,
  input  logic [CH_W-1:0]         memChan,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [NUM_CH-1:0]       atLast,
  output logic [MVOL_W-1:0]       masterVol,
  output logic [NUM_CH*LVL_W-1:0] chanLevel
);
  logic [PAGE_W-1:0] startPage [NUM_CH];
  logic [PAGE_W-1:0] stopPage  [NUM_CH];
  logic [ADDR_W-1:0] byteAddr  [NUM_CH];
  logic [LVL_W-1:0]  level     [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic regHit;
    assign regHit = (int'(strb.regCh) == i);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        startPage[i] <= '0;
        stopPage[i]  <= '0;
        byteAddr[i]  <= '0;
        level[i]     <= '0;
      end else begin
        if (strb.pageWr && regHit) begin
          if (strb.pageIsStop) begin
            if (strb.pageIsHigh) stopPage[i][15:8] <= strb.wrData;
            else                 stopPage[i][7:0]  <= strb.wrData;
          end else begin
            if (strb.pageIsHigh) startPage[i][15:8] <= strb.wrData;
            else                 startPage[i][7:0]  <= strb.wrData;
          end
        end
        if (strb.levelWr && regHit) level[i] <= strb.wrData;
        if (strb.keyOn[i])     byteAddr[i] <= {startPage[i], 8'h00};
        else if (strb.step[i]) byteAddr[i] <= byteAddr[i] + 1'b1;
      end
    end

    assign atLast[i] = (byteAddr[i] == {stopPage[i], 8'hFF});
    assign chanLevel[i*LVL_W +: LVL_W] = level[i];

    // R2: a start loads the first byte of the start page
    assert_start_load_R2: assert property (@(posedge clk) disable iff (!rstN)
      strb.keyOn[i] |=> (byteAddr[i] == {$past(startPage[i]), 8'h00}));
    // R5: an accepted step adds exactly one
    assert_step_one_R5: assert property (@(posedge clk) disable iff (!rstN)
      strb.step[i] |=> (byteAddr[i] == $past(byteAddr[i]) + 1'b1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) masterVol <= '0;
    else if (strb.masterWr) masterVol <= strb.wrData[MVOL_W-1:0];
  end

  assign memAddr = (int'(memChan) < NUM_CH) ? byteAddr[memChan] : '0;
endmodule

// File: rtl/smp_seq_top.sv
module smp_seq_top
  import seq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         regWrEn,
  input  logic [7:0]   regAddr,
  input  logic [7:0]   regWrData,
  output logic         memReq,
  output logic [2:0]   memChan,
  output logic [23:0]  memAddr,
  input  logic         memAck,
  output logic [5:0]   endPulse,
  output logic [5:0]   chanActive,
  output logic [5:0]   masterVol,
  output logic [47:0]  chanLevel
);
  seq_strobe_t       strb;
  logic [NUM_CH-1:0] atLast;

  seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .memAck(memAck), .atLast(atLast),
    .memReq(memReq), .memChan(memChan), .endPulse(endPulse),
    .chanActive(chanActive), .strb(strb)
  );

  seq_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .memChan(memChan),
    .memAddr(memAddr), .atLast(atLast), .masterVol(masterVol),
    .chanLevel(chanLevel)
  );
endmodule

// File: tb/smp_seq_top_tb_top.sv
module smp_seq_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic memAck = 1'b0;
  logic memReq;
  logic [2:0] memChan;
  logic [23:0] memAddr;
  logic [5:0] endPulse, chanActive, masterVol;
  logic [47:0] chanLevel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] mStart [6];
  logic [15:0] mStop  [6];
  logic [23:0] mAddr  [6];
  logic [7:0]  mLevel [6];
  logic [5:0]  mMaster;
  logic [5:0]  mActive;
  logic [5:0]  mEnd;
  int          mPtr;

  always #10 clk = ~clk;

  smp_seq_top dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .memReq(memReq), .memChan(memChan),
    .memAddr(memAddr), .memAck(memAck), .endPulse(endPulse),
    .chanActive(chanActive), .masterVol(masterVol), .chanLevel(chanLevel)
  );

  function automatic int pickGrant(logic [5:0] act, int ptr);
    for (int k = 0; k < 6; k++) begin
      if (act[(ptr + k) % 6]) return (ptr + k) % 6;
    end
    return -1;
  endfunction

  function automatic logic [47:0] packLevels();
    logic [47:0] v;
    for (int i = 0; i < 6; i++) v[i*8 +: 8] = mLevel[i];
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < 6; i++) begin
      mStart[i] = '0; mStop[i] = '0; mAddr[i] = '0; mLevel[i] = '0;
    end
    mMaster = '0; mActive = '0; mEnd = '0; mPtr = 0;
  endtask

  task automatic compareAll();
    int g;
    g = pickGrant(mActive, mPtr);
    check(chanActive == mActive, "R3 chanActive", 64'(chanActive), 64'(mActive));
    check(endPulse == mEnd, "R7 endPulse", 64'(endPulse), 64'(mEnd));
    check(memReq == (|mActive), "R2 memReq", 64'(memReq), 64'(|mActive));
    if (memReq && g >= 0) begin
      check(int'(memChan) == g, "R6 memChan", 64'(memChan), 64'(g));
      check(memAddr == mAddr[g], "R5 memAddr", 64'(memAddr), 64'(mAddr[g]));
    end
    check(masterVol == mMaster, "R10 masterVol", 64'(masterVol), 64'(mMaster));
    check(chanLevel == packLevels(), "R10 chanLevel", 64'(chanLevel), 64'(packLevels()));
  endtask

  // one cycle: called at a negative edge
  task automatic tick(input bit wr, input logic [7:0] a, input logic [7:0] d, input bit ak);
    logic [5:0] kOn, kOff, nEnd;
    int g, ch;
    compareAll();
    regWrEn = wr; regAddr = a; regWrData = d; memAck = ak;
    kOn = '0; kOff = '0; nEnd = '0;
    ch = int'(a[2:0]);
    if (wr && a == 8'h00) begin
      if (d[7]) kOff = d[5:0]; else kOn = d[5:0];
    end
    if (wr && a == 8'h01) mMaster = d[5:0];
    if (wr && a[7:3] == 5'b00001 && ch < 6) mLevel[ch] = d;
    if (wr && a[7:6] == 2'b00 && (a[5:4] == 2'b01 || a[5:4] == 2'b10) && ch < 6) begin
      if (a[5]) begin
        if (a[3]) mStop[ch][15:8] = d; else mStop[ch][7:0] = d;
      end else begin
        if (a[3]) mStart[ch][15:8] = d; else mStart[ch][7:0] = d;
      end
    end
    g = pickGrant(mActive, mPtr);
    if (ak && g >= 0) begin
      if (!kOn[g] && !kOff[g]) begin
        if (mAddr[g] == {mStop[g], 8'hFF}) nEnd[g] = 1'b1;
        else mAddr[g] = mAddr[g] + 1;
      end
      mPtr = (g + 1) % 6;
    end
    for (int i = 0; i < 6; i++) if (kOn[i]) mAddr[i] = {mStart[i], 8'h00};
    mActive = (mActive & ~kOff & ~nEnd) | kOn;
    mEnd = nEnd;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0; memAck = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    tick(1'b1, a, d, 1'b0);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 8'h00, 8'h00, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check(memReq == 1'b0 && endPulse == '0 && chanActive == '0, "R1 outputs",
          64'({memReq, endPulse, chanActive}), 64'd0);
    check(masterVol == '0 && chanLevel == '0, "R1 levels", 64'(chanLevel), 64'd0);

    // R4 page mapping: channel 3 start 0x1234
    wr(8'h12, 8'h34);
    wr(8'h1A, 8'h12);
    wr(8'h22, 8'h34);
    wr(8'h2A, 8'h12);
    wr(8'h00, 8'h04);
    check(memAddr == 24'h123400 && memChan == 3'd2, "R4 start page", 64'(memAddr), 64'h123400);
    check(chanActive == 6'b000100, "R2 only selected", 64'(chanActive), 64'h4);
    run(10);
    check(memAddr == 24'h12340A, "R5 ten steps", 64'(memAddr), 64'h12340A);
    // R8 restart reloads
    wr(8'h00, 8'h04);
    check(memAddr == 24'h123400, "R8 restart", 64'(memAddr), 64'h123400);
    // run to end of a single page: R7
    run(255);
    check(memAddr == 24'h1234FF, "R7 last byte", 64'(memAddr), 64'h1234FF);
    run(1);
    check(endPulse == 6'b000100 && chanActive == '0, "R7 end pulse", 64'({endPulse, chanActive}), 64'h100);
    tick(1'b0, 8'h00, 8'h00, 1'b0);
    check(endPulse == '0, "R7 one cycle", 64'(endPulse), 64'd0);

    // R9: stop command with ack on the last byte
    wr(8'h00, 8'h01);
    run(255);
    check(memAddr == 24'h0000FF, "R9 at last", 64'(memAddr), 64'hFF);
    tick(1'b1, 8'h00, 8'h81, 1'b1);
    check(endPulse == '0 && chanActive == '0, "R9 stop wins", 64'({endPulse, chanActive}), 64'd0);

    // R6 multiple channels and R3 partial stop
    wr(8'h00, 8'h3F);
    run(20);
    wr(8'h00, 8'h8A);
    check(chanActive == 6'b110101, "R3 partial stop", 64'(chanActive), 64'h35);
    run(12);

    // R10 levels, R11 unmapped writes
    wr(8'h01, 8'hFF);
    check(masterVol == 6'h3F, "R10 master bits", 64'(masterVol), 64'h3F);
    wr(8'h0D, 8'hC5);
    check(chanLevel[47:40] == 8'hC5, "R10 level ch6", 64'(chanLevel[47:40]), 64'hC5);
    wr(8'h0E, 8'h77);
    wr(8'h16, 8'h55);
    wr(8'h2E, 8'h55);
    wr(8'h40, 8'h3F);
    check(chanLevel == packLevels() && chanActive == mActive, "R11 ignored", 64'(chanLevel), 64'(packLevels()));
    wr(8'h00, 8'hBF);

    // constrained random
    for (int i = 0; i < 20000; i++) begin
      int r;
      r = int'($urandom % 200);
      if (r == 0)
        tick(1'b1, 8'h00, {$urandom % 2 == 0 ? 1'b0 : 1'b1, 1'b0, 6'($urandom)}, ($urandom % 4) != 0);
      else if (r < 5) begin
        int c;
        c = int'($urandom % 6);
        case ($urandom % 4)
          0: tick(1'b1, 8'h10 + 8'(c), 8'($urandom % 3), ($urandom % 4) != 0);
          1: tick(1'b1, 8'h20 + 8'(c), 8'(2 + $urandom % 3), ($urandom % 4) != 0);
          2: tick(1'b1, 8'h08 + 8'(c), 8'($urandom), ($urandom % 4) != 0);
          default: tick(1'b1, 8'(8'h30 + $urandom % 16), 8'($urandom), ($urandom % 4) != 0);
        endcase
      end else
        tick(1'b0, 8'h00, 8'h00, ($urandom % 4) != 0);
    end
    compareAll();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule